// File: doc/BRIEF.md
# Three-Tap PAM-4 Transmit Equalizer

This block is a digital feed-forward equalizer for the transmit side of a PAM-4 link. A stream of 2-bit symbols arrives with a valid strobe. For each symbol, the block forms a weighted sum of three symbols: the one that follows it (pre-cursor), the symbol itself (main cursor) and the one before it (post-cursor). The result is a signed amplitude code that goes to a DAC or line driver.

Each tap has two signed weights, one for the symbol's high bit and one for its low bit. This lets configuration change the spacing between the four levels, which predistorts the eye for nonlinear optical drivers. With equal high and low weights, the levels are uniform.

The pre-cursor and post-cursor weights are clamped to their legal de-emphasis ranges. The output is saturated to the DAC code width. Because the pre-cursor tap needs the next symbol, each result appears one symbol late.

Top module: `pam4_tx_fir`

## Requirements
- R1: While rst_ni is low and after it rises, until the first result, valid_o is 0 and out_o is 0.
- R2: Weights are signed COEF_W-bit numbers with FRAC_W (6) fractional bits, and out_o uses the same 1/64 units. For each tap, symbol bit 1 adds +2×(high weight) when it is 1 and −2×(high weight) when it is 0. Symbol bit 0 adds +1×(low weight) when it is 1 and −1×(low weight) when it is 0. With equal weights, codes 00, 01, 10 and 11 give the levels −3, −1, +1 and +3 times the weight.
- R3: The high-bit and low-bit weights of a tap act independently, so a ratio other than 2:1 moves the inner levels relative to the outer ones.
- R4: The result for symbol k is pre·level(k+1) + main·level(k) + post·level(k−1).
- R5: The result for symbol k is on out_o, with valid_o high for exactly one cycle, in the cycle after the clock edge that accepts symbol k+1. The first symbol after reset produces no result of its own on acceptance.
- R6: A slot that has not yet been filled since reset contributes 0. The first result therefore has no post-cursor part.
- R7: A cycle with valid_i low shifts nothing and leaves valid_o low the next cycle. out_o holds its value, and the next symbol continues the same history.
- R8: A positive pre-cursor weight acts as 0. A pre-cursor weight below −16 (−0.25) acts as −16.
- R9: A positive post-cursor weight acts as 0. A post-cursor weight below −32 (−0.5) acts as −32.
- R10: Main-cursor weights are used over their full signed range, including negative values.
- R11: A sum above 2^(OUT_W−1)−1 gives 511 and a sum below −2^(OUT_W−1) gives −512 (for OUT_W=10); the sum never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Symbol present on sym_i |
| sym_i | input | 2 | PAM-4 symbol, bit 1 high, bit 0 low |
| pre_msb_i | input | COEF_W | Pre-cursor high-bit weight |
| pre_lsb_i | input | COEF_W | Pre-cursor low-bit weight |
| main_msb_i | input | COEF_W | Main-cursor high-bit weight |
| main_lsb_i | input | COEF_W | Main-cursor low-bit weight |
| post_msb_i | input | COEF_W | Post-cursor high-bit weight |
| post_lsb_i | input | COEF_W | Post-cursor low-bit weight |
| valid_o | output | 1 | Result present on out_o |
| out_o | output | OUT_W | Signed, saturated drive code |

## Verification
The assertions check the handshake timing on every cycle:
- a result appears exactly when a symbol is accepted with an earlier one already held;
- idle cycles neither pulse valid_o nor disturb out_o;
- an all-zero weight set always yields a zero result.

The arithmetic can only be shown by the bench's scenarios, which compare results against hand-computed values. These cover the level mapping, the separate high and low weighting, the clamping of the side taps, the empty slots after reset, and saturation at both rails.

// File: rtl/pam4_fir_pkg.sv
package pam4_fir_pkg;
  typedef logic [1:0] sym_t;
  localparam int NTAPS    = 3;
  localparam int TAP_PRE  = 0;
  localparam int TAP_MAIN = 1;
  localparam int TAP_POST = 2;
endpackage

// File: rtl/pam4_coef_clamp.sv
module pam4_coef_clamp #(
  parameter int COEF_W = 8,
  parameter int LO     = -16,
  parameter bit BYPASS = 1'b0
) (
  input  logic signed [COEF_W-1:0] raw_i,
  output logic signed [COEF_W-1:0] eff_o
);
  if (BYPASS) begin : g_pass
    assign eff_o = raw_i;
  end else begin : g_clamp
    localparam logic signed [COEF_W-1:0] LO_V = COEF_W'(LO);
    always_comb begin
      if (!raw_i[COEF_W-1]) eff_o = '0;      // zero or positive
      else if (raw_i < LO_V) eff_o = LO_V;
      else eff_o = raw_i;
    end
  end
endmodule

// File: rtl/pam4_tap_term.sv
module pam4_tap_term
  import pam4_fir_pkg::*;
#(
  parameter int COEF_W = 8,
  localparam int TERM_W = COEF_W + 2
) (
  input  sym_t                     sym_i,
  input  logic                     occ_i,
  input  logic signed [COEF_W-1:0] w_msb_i,
  input  logic signed [COEF_W-1:0] w_lsb_i,
  output logic signed [TERM_W-1:0] term_o
);
  logic signed [TERM_W-1:0] m2, l1, m_part, l_part;

  always_comb begin
    m2     = {{2{w_msb_i[COEF_W-1]}}, w_msb_i} <<< 1;
    l1     = {{2{w_lsb_i[COEF_W-1]}}, w_lsb_i};
    m_part = sym_i[1] ? m2 : -m2;
    l_part = sym_i[0] ? l1 : -l1;
    term_o = occ_i ? (m_part + l_part) : '0;
  end
endmodule

// File: rtl/pam4_sat.sv
module pam4_sat #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 10
) (
  input  logic signed [IN_W-1:0]  in_i,
  output logic signed [OUT_W-1:0] out_o
);
  if (OUT_W >= IN_W) begin : g_wide
    assign out_o = {{(OUT_W-IN_W){in_i[IN_W-1]}}, in_i};
  end else begin : g_narrow
    localparam int MAX_I = (1 << (OUT_W-1)) - 1;
    localparam int MIN_I = -(1 << (OUT_W-1));
    localparam logic signed [IN_W-1:0] MAX_V = IN_W'(MAX_I);
    localparam logic signed [IN_W-1:0] MIN_V = IN_W'(MIN_I);
    always_comb begin
      if (in_i > MAX_V) out_o = OUT_W'(MAX_I);
      else if (in_i < MIN_V) out_o = OUT_W'(MIN_I);
      else out_o = in_i[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/pam4_tx_fir.sv
module pam4_tx_fir
  import pam4_fir_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int FRAC_W = 6,
  parameter int OUT_W  = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [1:0]               sym_i,
  input  logic signed [COEF_W-1:0] pre_msb_i,
  input  logic signed [COEF_W-1:0] pre_lsb_i,
  input  logic signed [COEF_W-1:0] main_msb_i,
  input  logic signed [COEF_W-1:0] main_lsb_i,
  input  logic signed [COEF_W-1:0] post_msb_i,
  input  logic signed [COEF_W-1:0] post_lsb_i,
  output logic                     valid_o,
  output logic signed [OUT_W-1:0]  out_o
);
  localparam int TERM_W  = COEF_W + 2;
  localparam int SUM_W   = TERM_W + 2;
  localparam int PRE_LO  = -(1 << (FRAC_W-2));   // -0.25
  localparam int POST_LO = -(1 << (FRAC_W-1));   // -0.5

  sym_t cur_q, prev_q;
  logic cur_vld_q, prev_vld_q;
  logic valid_q;
  logic signed [OUT_W-1:0] out_q;

  logic signed [COEF_W-1:0] raw_msb [NTAPS];
  logic signed [COEF_W-1:0] raw_lsb [NTAPS];
  logic signed [COEF_W-1:0] eff_msb [NTAPS];
  logic signed [COEF_W-1:0] eff_lsb [NTAPS];
  logic signed [TERM_W-1:0] term    [NTAPS];
  sym_t                     tap_sym [NTAPS];
  logic                     tap_occ [NTAPS];
  logic signed [SUM_W-1:0]  sum;
  logic signed [OUT_W-1:0]  sat_out;

  assign raw_msb[TAP_PRE]  = pre_msb_i;
  assign raw_lsb[TAP_PRE]  = pre_lsb_i;
  assign raw_msb[TAP_MAIN] = main_msb_i;
  assign raw_lsb[TAP_MAIN] = main_lsb_i;
  assign raw_msb[TAP_POST] = post_msb_i;
  assign raw_lsb[TAP_POST] = post_lsb_i;

  // pre tap sees the incoming symbol, main the held one, post the older one
  assign tap_sym[TAP_PRE]  = sym_i;
  assign tap_occ[TAP_PRE]  = 1'b1;
  assign tap_sym[TAP_MAIN] = cur_q;
  assign tap_occ[TAP_MAIN] = cur_vld_q;
  assign tap_sym[TAP_POST] = prev_q;
  assign tap_occ[TAP_POST] = prev_vld_q;

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    localparam int LO = (t == TAP_PRE) ? PRE_LO : POST_LO;
    localparam bit BYP = (t == TAP_MAIN);

    pam4_coef_clamp #(.COEF_W(COEF_W), .LO(LO), .BYPASS(BYP)) u_clamp_msb (
      .raw_i(raw_msb[t]), .eff_o(eff_msb[t])
    );
    pam4_coef_clamp #(.COEF_W(COEF_W), .LO(LO), .BYPASS(BYP)) u_clamp_lsb (
      .raw_i(raw_lsb[t]), .eff_o(eff_lsb[t])
    );
    pam4_tap_term #(.COEF_W(COEF_W)) u_term (
      .sym_i  (tap_sym[t]),
      .occ_i  (tap_occ[t]),
      .w_msb_i(eff_msb[t]),
      .w_lsb_i(eff_lsb[t]),
      .term_o (term[t])
    );
  end

  always_comb begin
    sum = '0;
    for (int t = 0; t < NTAPS; t++) begin
      sum = sum + {{(SUM_W-TERM_W){term[t][TERM_W-1]}}, term[t]};
    end
  end

  pam4_sat #(.IN_W(SUM_W), .OUT_W(OUT_W)) u_sat (
    .in_i (sum),
    .out_o(sat_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= '0;
      prev_q     <= '0;
      cur_vld_q  <= 1'b0;
      prev_vld_q <= 1'b0;
      valid_q    <= 1'b0;
      out_q      <= '0;
    end else begin
      valid_q <= valid_i & cur_vld_q;
      if (valid_i) begin
        cur_q      <= sym_i;
        cur_vld_q  <= 1'b1;
        prev_q     <= cur_q;
        prev_vld_q <= cur_vld_q;
        if (cur_vld_q) out_q <= sat_out;
      end
    end
  end

  assign valid_o = valid_q;
  assign out_o   = out_q;
endmodule

// File: rtl/pam4_tx_fir_chk.sv
module pam4_tx_fir_chk #(
  parameter int COEF_W = 8,
  parameter int OUT_W  = 10
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [COEF_W-1:0] pre_msb_i,
  input logic signed [COEF_W-1:0] pre_lsb_i,
  input logic signed [COEF_W-1:0] main_msb_i,
  input logic signed [COEF_W-1:0] main_lsb_i,
  input logic signed [COEF_W-1:0] post_msb_i,
  input logic signed [COEF_W-1:0] post_lsb_i,
  input logic                     valid_o,
  input logic signed [OUT_W-1:0]  out_o
);
  logic seen_q;
  logic all_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else if (valid_i) seen_q <= 1'b1;
  end

  assign all_zero = (pre_msb_i == '0) && (pre_lsb_i == '0) &&
                    (main_msb_i == '0) && (main_lsb_i == '0) &&
                    (post_msb_i == '0) && (post_lsb_i == '0);

  a_r5_result_needs_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(valid_i) && $past(seen_q)));

  a_r5_result_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(seen_q)) |-> valid_o);

  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> (!valid_o && $stable(out_o)));

  a_r4_zero_weights: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(all_zero)) |-> (out_o == '0));
endmodule

bind pam4_tx_fir pam4_tx_fir_chk #(.COEF_W(COEF_W), .OUT_W(OUT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .pre_msb_i (pre_msb_i),
  .pre_lsb_i (pre_lsb_i),
  .main_msb_i(main_msb_i),
  .main_lsb_i(main_lsb_i),
  .post_msb_i(post_msb_i),
  .post_lsb_i(post_lsb_i),
  .valid_o   (valid_o),
  .out_o     (out_o)
);

// File: tb/pam4_tx_fir_tb.sv
module pam4_tx_fir_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COEF_W = 8;
  localparam int OUT_W  = 10;
  localparam int NVEC   = 7;

  // table: pre=-8, main=48, post=-8 on both bits
  localparam logic [1:0] VSYM [NVEC] = '{2'b00, 2'b11, 2'b01, 2'b10, 2'b11, 2'b00, 2'b10};
  localparam logic       VVLD [NVEC] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int         VEXP [NVEC] = '{0, -168, 176, -80, 32, 160, -176};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] sym_i = '0;
  logic signed [COEF_W-1:0] pre_msb_i = '0, pre_lsb_i = '0;
  logic signed [COEF_W-1:0] main_msb_i = '0, main_lsb_i = '0;
  logic signed [COEF_W-1:0] post_msb_i = '0, post_lsb_i = '0;
  logic valid_o;
  logic signed [OUT_W-1:0] out_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pam4_tx_fir #(.COEF_W(COEF_W), .FRAC_W(6), .OUT_W(OUT_W)) u_dut (
    .clk_i, .rst_ni, .valid_i, .sym_i,
    .pre_msb_i, .pre_lsb_i, .main_msb_i, .main_lsb_i, .post_msb_i, .post_lsb_i,
    .valid_o, .out_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int exp_vld, input int exp_out);
    chk({req, " valid_o"}, int'(valid_o), exp_vld);
    if (exp_vld != 0) chk({req, " out_o"}, int'(out_o), exp_out);
  endtask

  task automatic set_w(input int pm, input int pl, input int mm, input int ml,
                       input int qm, input int ql);
    pre_msb_i  = COEF_W'(pm); pre_lsb_i  = COEF_W'(pl);
    main_msb_i = COEF_W'(mm); main_lsb_i = COEF_W'(ml);
    post_msb_i = COEF_W'(qm); post_lsb_i = COEF_W'(ql);
  endtask

  task automatic step(input logic [1:0] s);
    @(negedge clk_i);
    valid_i = 1'b1;
    sym_i   = s;
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0;
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R5 act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    #1;
    chk("R1 in reset valid_o", int'(valid_o), 0);
    chk("R1 in reset out_o", int'(out_o), 0);
    rst_ni = 1'b1;
    idle();
    chk("R1 after reset valid_o", int'(valid_o), 0);
    chk("R1 after reset out_o", int'(out_o), 0);

    // R2 R4 R5 R6 table walk
    set_w(-8, -8, 48, 48, -8, -8);
    for (int i = 0; i < NVEC; i++) begin
      step(VSYM[i]);
      chk_out($sformatf("R4 R5 R6 vec%0d", i), int'(VVLD[i]), VEXP[i]);
    end

    // R7: idle cycles hold, history continues
    idle();
    chk_out("R7 idle1", 0, 0);
    chk("R7 idle1 hold", int'(out_o), -176);
    idle();
    chk("R7 idle2 hold", int'(out_o), -176);
    step(2'b01);
    chk_out("R7 resume", 1, 80);
    idle();
    chk_out("R5 single pulse", 0, 0);

    // R3: high bit only, then low bit only
    do_reset();
    set_w(0, 0, 32, 0, 0, 0);
    step(2'b11);
    step(2'b00);
    chk_out("R3 msb only 11", 1, 64);
    step(2'b01);
    chk_out("R3 msb only 00", 1, -64);
    do_reset();
    set_w(0, 0, 0, 32, 0, 0);
    step(2'b10);
    step(2'b11);
    chk_out("R3 lsb only 10", 1, -32);

    // R2 R3: unequal ratio moves inner levels
    do_reset();
    set_w(0, 0, 20, 16, 0, 0);
    step(2'b11);
    step(2'b10);
    chk_out("R3 ratio 11", 1, 56);
    step(2'b01);
    chk_out("R3 ratio 10", 1, 24);
    step(2'b00);
    chk_out("R2 ratio 01", 1, -24);
    step(2'b00);
    chk_out("R2 ratio 00", 1, -56);

    // R8: pre-cursor clamp
    do_reset();
    set_w(20, 20, 0, 0, 0, 0);
    step(2'b11);
    step(2'b11);
    chk_out("R8 positive pre", 1, 0);
    set_w(-40, -40, 0, 0, 0, 0);
    step(2'b11);
    chk_out("R8 pre floor", 1, -48);

    // R9: post-cursor clamp
    do_reset();
    set_w(0, 0, 0, 0, -60, -60);
    step(2'b11);
    step(2'b00);
    step(2'b00);
    chk_out("R9 post floor", 1, -96);
    set_w(0, 0, 0, 0, 5, 5);
    step(2'b11);
    chk_out("R9 positive post", 1, 0);

    // R10: negative main weight
    do_reset();
    set_w(0, 0, -128, -128, 0, 0);
    step(2'b11);
    step(2'b00);
    chk_out("R10 main negative", 1, -384);

    // R11: saturation at both rails
    do_reset();
    set_w(-16, -16, 127, 127, -32, -32);
    step(2'b00);
    step(2'b11);
    chk_out("R11 below rail", 1, -429);
    step(2'b00);
    chk_out("R11 upper rail", 1, 511);
    step(2'b11);
    chk_out("R11 lower rail", 1, -512);

    idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule